// File: doc/BRIEF.md
# Multidrop Node Address Filter Controller

This block sits between the character side of a multidrop serial receiver and transmitter and two circular byte buffers. Every received character carries a type bit that marks it as an address or as data. An address character is compared against the programmed node address. On a mismatch the block pulses a request that puts the receiver back to sleep. On a match the receiver is left awake. A data character is appended to the receive ring, which also clears a receive-empty flag. When the ring is full, the character is dropped and a sticky overflow flag is raised.

On the transmit side, software fills a transmit ring. A send command then places the target node address on the transmitter's address port and enables draining. Bytes leave the ring in order, one per transmitter request. When the last byte leaves, the block sets a transmit-empty flag and disables draining by itself.

The data paths use valid/ready handshakes. A transfer happens in a cycle where valid and ready are both high. The character input is always ready, so overload shows as dropped data, not as back-pressure. The transmit push port drops ready while its ring is full. The receive pop port and the transmit byte port hold valid and data stable until ready is seen. The transmitter's ready acts as its byte request. Each ring has SLOTS slots and holds at most SLOTS-1 bytes. Both pointers wrap modulo SLOTS, and SLOTS need not be a power of two.

Top module: `mdrop_ring_ctrl`

## Requirements
- R1: After reset, rx_empty=1, tx_empty=1, rx_overflow=0, rx_sleep_set=0, txa_valid=0, txd_valid=0, rxp_valid=0 and txp_ready=1.
- R2: rxc_ready is always 1. rxc_is_addr=1 marks an address character and rxc_is_addr=0 marks a data character.
- R3: An address character equal to node_addr gives no rx_sleep_set pulse and stores nothing (rxp_valid stays as it was).
- R4: An address character that differs from node_addr drives rx_sleep_set high for exactly the one cycle after it is accepted.
- R5: A data character accepted while the receive ring is not full is stored. In the following cycle rx_empty=0 and rxp_valid=1, and rxp_data presents the stored bytes in arrival order.
- R6: A ring holds SLOTS-1 bytes. While the transmit ring holds that many, txp_ready=0.
- R7: A data character that arrives while the receive ring is full is dropped, and rx_overflow becomes 1 and stays 1 until reset.
- R8: A receive pop that takes the last stored byte sets rx_empty=1 and rxp_valid=0 in the next cycle.
- R9: A send_cmd pulse gives txa_valid=1 with txa_data equal to the target_addr of that cycle for exactly one cycle. From that same cycle, txd_valid=1 while the transmit ring is not empty.
- R10: Transmit bytes leave in push order. After the last byte is taken, tx_empty=1 and txd_valid=0, and txd_valid stays 0 through later pushes until the next send_cmd.
- R11: A transmit push clears tx_empty in the next cycle.
- R12: Pointers wrap modulo SLOTS, so order is kept across any number of fill and drain rounds of any length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| node_addr | input | 8 | Programmed node address |
| rxc_valid | input | 1 | Received character valid |
| rxc_ready | output | 1 | Character accept (always 1) |
| rxc_is_addr | input | 1 | Type bit: 1 = address, 0 = data |
| rxc_data | input | 8 | Received character |
| rx_sleep_set | output | 1 | One-cycle request to re-arm receiver sleep |
| rx_empty | output | 1 | Receive-empty flag |
| rx_overflow | output | 1 | Sticky receive overflow flag |
| rxp_valid | output | 1 | Receive ring has a byte to pop |
| rxp_ready | input | 1 | Software pops the receive byte |
| rxp_data | output | 8 | Oldest receive byte |
| txp_valid | input | 1 | Software push valid |
| txp_ready | output | 1 | Transmit ring has room |
| txp_data | input | 8 | Byte to push |
| send_cmd | input | 1 | Start a message to target_addr |
| target_addr | input | 8 | Target node address |
| txa_valid | output | 1 | Address-port write strobe |
| txa_data | output | 8 | Address byte for the transmitter |
| txd_valid | output | 1 | Transmit byte available |
| txd_ready | input | 1 | Transmitter byte request |
| txd_data | output | 8 | Transmit byte |
| tx_empty | output | 1 | Transmit-empty flag |

## Verification
The embedded assertions check the per-cycle rules on every cycle:
- ring occupancy never exceeds SLOTS-1;
- occupancy steps by one on a lone push or pop;
- a matching address never pulses sleep, while a mismatch always does;
- a stored data character clears rx_empty;
- the overflow flag is sticky;
- a send command yields the address strobe;
- draining the last byte sets tx_empty and disables draining.

Only the bench's scenarios can show the following:
- byte ordering through both rings across many wrap-arounds of a five-slot configuration;
- the full sweep of all address values against the node address;
- loss of exactly the excess characters on overflow;
- the rule that draining stays off after late pushes until the next send command.

// File: rtl/mdrop_pkg.sv
package mdrop_pkg;
  parameter int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/mdrop_ring.sv
module mdrop_ring
  import mdrop_pkg::*;
#(
  parameter int unsigned SLOTS = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  byte_t                        push_data,
  input  logic                         pop,
  output byte_t                        head_data,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(SLOTS+1)-1:0]   count
);
  localparam int unsigned PW  = (SLOTS > 2) ? $clog2(SLOTS) : 1;
  localparam int unsigned CW  = $clog2(SLOTS+1);
  localparam int unsigned CAP = SLOTS - 1;

  byte_t          mem [SLOTS];
  logic [PW-1:0]  head, tail;
  logic           do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(SLOTS-1)) ? '0 : p + PW'(1);
  endfunction

  assign full      = (step(tail) == head);
  assign empty     = (head == tail);
  assign do_push   = push && !full;
  assign do_pop    = pop && !empty;
  assign head_data = mem[head];
  assign count     = (tail >= head) ? CW'(tail - head)
                                    : CW'(CW'(tail) + CW'(SLOTS) - CW'(head));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else begin
      if (do_push) tail <= step(tail);
      if (do_pop)  head <= step(head);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[tail] <= push_data;
  end

  // R6
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(CAP));

  // R12
  push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_push && !do_pop) |=> (count == $past(count) + CW'(1)));

  // R12
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push) |=> (count == $past(count) - CW'(1)));
endmodule

// File: rtl/mdrop_rx_filter.sv
module mdrop_rx_filter
  import mdrop_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chr_valid,
  input  logic          chr_is_addr,
  input  byte_t         chr_data,
  input  byte_t         node_addr,
  input  logic          ring_full,
  input  logic          pop_fire,
  input  logic [CW-1:0] ring_count,
  output logic          store,
  output logic          sleep_set,
  output logic          overflow,
  output logic          empty_flag
);
  logic addr_seen, data_seen;

  assign addr_seen = chr_valid && chr_is_addr;
  assign data_seen = chr_valid && !chr_is_addr;
  assign store     = data_seen && !ring_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sleep_set  <= 1'b0;
      overflow   <= 1'b0;
      empty_flag <= 1'b1;
    end else begin
      sleep_set <= addr_seen && (chr_data != node_addr);
      if (data_seen && ring_full) overflow <= 1'b1;
      if (store)
        empty_flag <= 1'b0;
      else if (pop_fire && ring_count == CW'(1))
        empty_flag <= 1'b1;
    end
  end

  // R3
  match_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_seen && chr_data == node_addr) |=> !sleep_set);

  // R4
  mismatch_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_seen && chr_data != node_addr) |=> sleep_set);

  // R5
  store_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    store |=> !empty_flag);

  // R7
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/mdrop_tx_drain.sv
module mdrop_tx_drain
  import mdrop_pkg::*;
#(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          send_cmd,
  input  byte_t         target_addr,
  input  logic          push_fire,
  input  logic          pop_fire,
  input  logic [CW-1:0] ring_count,
  output logic          drain_en,
  output logic          addr_valid,
  output byte_t         addr_data,
  output logic          empty_flag
);
  logic last_out;

  assign last_out = pop_fire && (ring_count == CW'(1)) && !push_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_en   <= 1'b0;
      addr_valid <= 1'b0;
      addr_data  <= '0;
      empty_flag <= 1'b1;
    end else begin
      addr_valid <= send_cmd;
      if (send_cmd) addr_data <= target_addr;
      if (send_cmd)
        drain_en <= 1'b1;
      else if (last_out)
        drain_en <= 1'b0;
      if (push_fire)
        empty_flag <= 1'b0;
      else if (last_out)
        empty_flag <= 1'b1;
    end
  end

  // R9
  send_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    send_cmd |=> (addr_valid && addr_data == $past(target_addr) && drain_en));

  // R10
  drain_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (last_out && !send_cmd) |=> (!drain_en && empty_flag));

  // R11
  push_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |=> !empty_flag);
endmodule

// File: rtl/mdrop_ring_ctrl.sv
module mdrop_ring_ctrl
  import mdrop_pkg::*;
#(
  parameter int unsigned SLOTS = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t node_addr,
  input  logic  rxc_valid,
  output logic  rxc_ready,
  input  logic  rxc_is_addr,
  input  byte_t rxc_data,
  output logic  rx_sleep_set,
  output logic  rx_empty,
  output logic  rx_overflow,
  output logic  rxp_valid,
  input  logic  rxp_ready,
  output byte_t rxp_data,
  input  logic  txp_valid,
  output logic  txp_ready,
  input  byte_t txp_data,
  input  logic  send_cmd,
  input  byte_t target_addr,
  output logic  txa_valid,
  output byte_t txa_data,
  output logic  txd_valid,
  input  logic  txd_ready,
  output byte_t txd_data,
  output logic  tx_empty
);
  localparam int unsigned CW = $clog2(SLOTS+1);

  logic          rx_store, rx_full, rx_ring_empty, rx_pop_fire;
  logic [CW-1:0] rx_count;
  logic          tx_full, tx_ring_empty, tx_push_fire, tx_pop_fire, drain_en;
  logic [CW-1:0] tx_count;

  assign rxc_ready    = 1'b1;
  assign rxp_valid    = !rx_ring_empty;
  assign rx_pop_fire  = rxp_valid && rxp_ready;
  assign txp_ready    = !tx_full;
  assign tx_push_fire = txp_valid && txp_ready;
  assign txd_valid    = drain_en && !tx_ring_empty;
  assign tx_pop_fire  = txd_valid && txd_ready;

  mdrop_ring #(.SLOTS(SLOTS)) u_rx_ring (
    .clk(clk), .rst_n(rst_n),
    .push(rx_store), .push_data(rxc_data),
    .pop(rx_pop_fire), .head_data(rxp_data),
    .full(rx_full), .empty(rx_ring_empty), .count(rx_count)
  );

  mdrop_rx_filter #(.CW(CW)) u_rx_filter (
    .clk(clk), .rst_n(rst_n),
    .chr_valid(rxc_valid), .chr_is_addr(rxc_is_addr), .chr_data(rxc_data),
    .node_addr(node_addr), .ring_full(rx_full),
    .pop_fire(rx_pop_fire), .ring_count(rx_count),
    .store(rx_store), .sleep_set(rx_sleep_set),
    .overflow(rx_overflow), .empty_flag(rx_empty)
  );

  mdrop_ring #(.SLOTS(SLOTS)) u_tx_ring (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push_fire), .push_data(txp_data),
    .pop(tx_pop_fire), .head_data(txd_data),
    .full(tx_full), .empty(tx_ring_empty), .count(tx_count)
  );

  mdrop_tx_drain #(.CW(CW)) u_tx_drain (
    .clk(clk), .rst_n(rst_n),
    .send_cmd(send_cmd), .target_addr(target_addr),
    .push_fire(tx_push_fire), .pop_fire(tx_pop_fire), .ring_count(tx_count),
    .drain_en(drain_en), .addr_valid(txa_valid), .addr_data(txa_data),
    .empty_flag(tx_empty)
  );

  // R2
  always_comb rxc_ready_chk: assert (rxc_ready);
endmodule

// File: tb/tb_mdrop_ring_ctrl.sv
module tb_mdrop_ring_ctrl;
  localparam int SLOTS = 5;
  localparam int CAP   = SLOTS - 1;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] node_addr = 8'h21;
  logic       rxc_valid = 0, rxc_is_addr = 0, rxp_ready = 0;
  logic [7:0] rxc_data = 0, txp_data = 0, target_addr = 0;
  logic       txp_valid = 0, send_cmd = 0, txd_ready = 0;
  logic       rxc_ready, rx_sleep_set, rx_empty, rx_overflow, rxp_valid;
  logic       txp_ready, txa_valid, txd_valid, tx_empty;
  logic [7:0] rxp_data, txa_data, txd_data;

  int checks = 0, fails = 0;
  int rx_seq = 0, tx_seq = 0;

  always #2 clk = ~clk;

  mdrop_ring_ctrl #(.SLOTS(SLOTS)) dut (
    .clk(clk), .rst_n(rst_n), .node_addr(node_addr),
    .rxc_valid(rxc_valid), .rxc_ready(rxc_ready), .rxc_is_addr(rxc_is_addr),
    .rxc_data(rxc_data), .rx_sleep_set(rx_sleep_set), .rx_empty(rx_empty),
    .rx_overflow(rx_overflow), .rxp_valid(rxp_valid), .rxp_ready(rxp_ready),
    .rxp_data(rxp_data), .txp_valid(txp_valid), .txp_ready(txp_ready),
    .txp_data(txp_data), .send_cmd(send_cmd), .target_addr(target_addr),
    .txa_valid(txa_valid), .txa_data(txa_data), .txd_valid(txd_valid),
    .txd_ready(txd_ready), .txd_data(txd_data), .tx_empty(tx_empty)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rx_char(input bit is_addr, input logic [7:0] d);
    @(negedge clk);
    chk(rxc_ready == 1'b1, "R2 rxc_ready", rxc_ready, 1);
    rxc_valid = 1; rxc_is_addr = is_addr; rxc_data = d;
    @(negedge clk);
    rxc_valid = 0;
  endtask

  task automatic tx_push(input logic [7:0] d);
    @(negedge clk);
    txp_valid = 1; txp_data = d;
    @(negedge clk);
    txp_valid = 0;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rx_empty == 1 && tx_empty == 1, "R1 empty flags", {rx_empty, tx_empty}, 3);
    chk(rx_overflow == 0 && rx_sleep_set == 0, "R1 ovf/sleep", {rx_overflow, rx_sleep_set}, 0);
    chk(txa_valid == 0 && txd_valid == 0 && rxp_valid == 0, "R1 valids",
        {txa_valid, txd_valid, rxp_valid}, 0);
    chk(txp_ready == 1, "R1 txp_ready", txp_ready, 1);

    // R3 R4: exhaustive address sweep
    for (int a = 0; a < 256; a++) begin
      rx_char(1'b1, 8'(a));
      if (a == 8'h21) begin
        chk(rx_sleep_set == 0, "R3 match no sleep", rx_sleep_set, 0);
        chk(rxp_valid == 0 && rx_empty == 1, "R3 nothing stored", rxp_valid, 0);
      end else begin
        chk(rx_sleep_set == 1, "R4 mismatch sleep", rx_sleep_set, 1);
      end
      @(negedge clk);
      chk(rx_sleep_set == 0, "R4 single pulse", rx_sleep_set, 0);
    end

    // R5 R8 R12: receive rounds of every fill level, repeated to wrap
    for (int r = 0; r < 3; r++) begin
      for (int n = 1; n <= CAP; n++) begin
        for (int k = 0; k < n; k++) begin
          rx_char(1'b0, 8'(rx_seq + k));
          chk(rx_empty == 0 && rxp_valid == 1, "R5 stored", rx_empty, 0);
          chk(rx_sleep_set == 0, "R5 data no sleep", rx_sleep_set, 0);
        end
        for (int k = 0; k < n; k++) begin
          @(negedge clk);
          chk(rxp_valid == 1 && rxp_data == 8'(rx_seq + k), "R12 rx order",
              rxp_data, 8'(rx_seq + k));
          rxp_ready = 1;
        end
        @(negedge clk);
        rxp_ready = 0;
        chk(rx_empty == 1 && rxp_valid == 0, "R8 empty after pop", rx_empty, 1);
        rx_seq += n;
      end
    end
    chk(rx_overflow == 0, "R7 no overflow yet", rx_overflow, 0);

    // R7: overfill by two
    for (int k = 0; k < CAP + 2; k++) rx_char(1'b0, 8'(rx_seq + k));
    chk(rx_overflow == 1, "R7 overflow set", rx_overflow, 1);
    for (int k = 0; k < CAP; k++) begin
      @(negedge clk);
      chk(rxp_data == 8'(rx_seq + k), "R7 kept bytes", rxp_data, 8'(rx_seq + k));
      rxp_ready = 1;
    end
    @(negedge clk);
    rxp_ready = 0;
    chk(rxp_valid == 0, "R7 excess dropped", rxp_valid, 0);
    chk(rx_overflow == 1, "R7 sticky", rx_overflow, 1);

    // R6 R9 R10 R11 R12: transmit rounds
    for (int r = 0; r < 3; r++) begin
      for (int n = 1; n <= CAP; n++) begin
        for (int k = 0; k < n; k++) begin
          tx_push(8'(tx_seq + k));
          chk(tx_empty == 0, "R11 push clears empty", tx_empty, 0);
          chk(txd_valid == 0, "R10 idle before send", txd_valid, 0);
        end
        chk(txp_ready == (n < CAP), "R6 full blocks push", txp_ready, n < CAP);
        @(negedge clk);
        send_cmd = 1; target_addr = 8'(8'h80 + n + r);
        @(negedge clk);
        send_cmd = 0;
        chk(txa_valid == 1 && txa_data == 8'(8'h80 + n + r), "R9 address write",
            txa_data, 8'(8'h80 + n + r));
        chk(txd_valid == 1, "R9 drain enabled", txd_valid, 1);
        for (int k = 0; k < n; k++) begin
          if (k > 0) @(negedge clk);
          if (k == 1) chk(txa_valid == 0, "R9 strobe one cycle", txa_valid, 0);
          chk(txd_valid == 1 && txd_data == 8'(tx_seq + k), "R10 tx order",
              txd_data, 8'(tx_seq + k));
          txd_ready = 1;
        end
        @(negedge clk);
        txd_ready = 0;
        chk(txd_valid == 0 && tx_empty == 1, "R10 drain done", {txd_valid, tx_empty}, 1);
        tx_seq += n;
      end
    end

    // R10: late push stays parked until next send
    tx_push(8'hA5);
    chk(tx_empty == 0 && txd_valid == 0, "R10 stays off", txd_valid, 0);
    @(negedge clk);
    send_cmd = 1; target_addr = 8'h3C;
    @(negedge clk);
    send_cmd = 0;
    chk(txd_valid == 1 && txd_data == 8'hA5, "R10 resumes", txd_data, 8'hA5);
    txd_ready = 1;
    @(negedge clk);
    txd_ready = 0;
    chk(tx_empty == 1 && txd_valid == 0, "R10 final empty", tx_empty, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule